// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous on-chip requester and an external asynchronous static RAM that has separate data-in and data-out pins (64K words of 4 bits by default). The requester presents an address, a write word and a read/write flag. The block accepts a request only while idle. It holds the address and the write word on the memory pins for the whole access. It drives active-low chip-select and write-strobe outputs. All strobe timing is counted in clock cycles.

A read keeps chip-select low for a fixed access window. At the end of that window the memory output is captured into a holding register and returned with a one-cycle valid pulse. A write has three phases: a setup phase, a write-strobe pulse and a hold phase, each with its own cycle count. The write strobe always rises before chip-select, so the end of every write is set by the write strobe.

A mode input picks how the memory's outputs behave during the write strobe. In echo mode they show the incoming data. In quiet mode they float. The block reports, cycle by cycle, whether the memory's outputs are being driven. The mode is latched with each request.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and at the first cycle after it: chip-select and write strobe are high (inactive), `req_ready` is 1, and `ack`, `rd_valid` and `mem_out_driven` are 0.
- R2: A read accepted at clock edge E0 holds chip-select low with the write strobe high for exactly ACC_CYC cycles, and then releases chip-select. The memory output present at edge E0+ACC_CYC is captured into `rd_data`. `rd_valid` and `ack` are then high for that single following cycle.
- R3: A write accepted at edge E0 follows a fixed sequence while chip-select stays low. First, the write strobe is high for SETUP_CYC cycles. Next, it is low for exactly PULSE_CYC cycles. Last, it is high again for HOLD_CYC cycles. After that, chip-select returns high.
- R4: `ack` is high for exactly one cycle, in the cycle after the last active cycle of chip-select, for both reads and writes. It is never high in two consecutive cycles.
- R5: `req_ready` is 1 only while chip-select is high. A request presented while the block is busy is ignored: it creates no extra transaction, does not change the current address or data, and does not change the timing.
- R6: `mem_out_driven` is 1 in every cycle where chip-select is low and the write strobe is high. It is 0 whenever chip-select is high. While the write strobe is low it equals the mode latched for that write (1 = echo, 0 = quiet).
- R7: The mode is sampled only when a request is accepted. Changing `echo_mode` during a transaction has no effect on `mem_out_driven`.
- R8: The write strobe is low only while chip-select is low. It never falls in a cycle that directly follows a cycle in which chip-select was high.
- R9: `mem_addr` and `mem_din` do not change in any cycle where chip-select was already low in the previous cycle.
- R10: `rd_data` changes only in a cycle where `rd_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write word |
| echo_mode | input | 1 | 1 = memory echoes write data, 0 = memory floats during the write strobe |
| req_ready | output | 1 | Idle; a request is accepted at the next edge |
| ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | `rd_data` carries a new read result |
| rd_data | output | DATA_W | Captured read word |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_din | output | DATA_W | Data to the memory input pins |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dout | input | DATA_W | Data from the memory output pins |
| mem_out_driven | output | 1 | Memory outputs are currently driven |

## Verification
The bench builds the block with an 8-bit address, an access window of 3 cycles, a setup of 2, a pulse of 3 and a hold of 2. Every phase is then longer than one cycle, so an off-by-one in any counter moves a strobe edge that the bench can see. The memory model returns the stored word only after chip-select has been low for the full access window, so sampling one cycle early returns wrong data. It also rejects any write strobe that is not exactly PULSE_CYC cycles long. The 256-word space lets random write/read-back runs in both modes revisit addresses. Busy-time requests that carry a flipped mode and a different address show up both in the strobe timing and in later read-backs.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } seq_state_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int ACC_CYC   = 3,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             phase_expired,
  output logic             phase_load,
  output logic [CNT_W-1:0] phase_len,
  output logic             start,
  output logic             rd_done,
  output logic             wr_done,
  output logic             idle,
  output logic             cs_n,
  output logic             we_n
);

  localparam logic [CNT_W-1:0] ACC_LEN   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LEN = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LEN = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LEN  = CNT_W'(HOLD_CYC - 1);

  seq_state_t state_q, state_d;
  logic       cs_n_q, cs_n_d;
  logic       we_n_q, we_n_d;

  always_comb begin
    state_d    = state_q;
    phase_load = 1'b0;
    phase_len  = '0;
    start      = 1'b0;
    rd_done    = 1'b0;
    wr_done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          start      = 1'b1;
          phase_load = 1'b1;
          if (req_write) begin
            state_d   = ST_WSETUP;
            phase_len = SETUP_LEN;
          end else begin
            state_d   = ST_READ;
            phase_len = ACC_LEN;
          end
        end
      end
      ST_READ: begin
        if (phase_expired) begin
          state_d = ST_IDLE;
          rd_done = 1'b1;
        end
      end
      ST_WSETUP: begin
        if (phase_expired) begin
          state_d    = ST_WPULSE;
          phase_load = 1'b1;
          phase_len  = PULSE_LEN;
        end
      end
      ST_WPULSE: begin
        if (phase_expired) begin
          state_d    = ST_WHOLD;
          phase_load = 1'b1;
          phase_len  = HOLD_LEN;
        end
      end
      ST_WHOLD: begin
        if (phase_expired) begin
          state_d = ST_IDLE;
          wr_done = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    cs_n_d = (state_d == ST_IDLE);
    we_n_d = (state_d != ST_WPULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      we_n_q  <= we_n_d;
    end
  end

  assign idle = (state_q == ST_IDLE);
  assign cs_n = cs_n_q;
  assign we_n = we_n_q;

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_done,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              echo_mode,
  input  logic [DATA_W-1:0] mem_dout,
  input  logic              cs_n,
  input  logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ack,
  output logic              out_driven
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              mode_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mode_q  <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mode_q  <= echo_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_done) begin
      rdata_q <= mem_dout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_done;
      ack_q    <= rd_done | wr_done;
    end
  end

  assign addr       = addr_q;
  assign wdata      = wdata_q;
  assign rd_data    = rdata_q;
  assign rd_valid   = rvalid_q;
  assign ack        = ack_q;
  assign out_driven = ~cs_n & (we_n | mode_q);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 4,
  parameter int ACC_CYC   = 3,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              echo_mode,
  output logic              req_ready,
  output logic              ack,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_din,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  input  logic [DATA_W-1:0] mem_dout,
  output logic              mem_out_driven
);

  localparam int MAX_CYC = max_of4(ACC_CYC, SETUP_CYC, PULSE_CYC, HOLD_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             phase_load;
  logic [CNT_W-1:0] phase_len;
  logic             phase_expired;
  logic             start;
  logic             rd_done;
  logic             wr_done;
  logic             idle;
  logic             cs_n;
  logic             we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (phase_load),
    .load_val (phase_len),
    .expired  (phase_expired)
  );

  sram_ctl_seq #(
    .ACC_CYC   (ACC_CYC),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .phase_expired (phase_expired),
    .phase_load    (phase_load),
    .phase_len     (phase_len),
    .start         (start),
    .rd_done       (rd_done),
    .wr_done       (wr_done),
    .idle          (idle),
    .cs_n          (cs_n),
    .we_n          (we_n)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .rd_done    (rd_done),
    .wr_done    (wr_done),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .echo_mode  (echo_mode),
    .mem_dout   (mem_dout),
    .cs_n       (cs_n),
    .we_n       (we_n),
    .addr       (mem_addr),
    .wdata      (mem_din),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .ack        (ack),
    .out_driven (mem_out_driven)
  );

  assign req_ready = idle;
  assign mem_cs_n  = cs_n;
  assign mem_we_n  = we_n;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 4,
  parameter int PULSE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              we_n,
  input logic              ready,
  input logic              ack,
  input logic              rd_valid,
  input logic              out_driven,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] rd_data
);

  int unsigned low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= 0;
    end else if (!we_n) begin
      low_cnt_q <= low_cnt_q + 1;
    end else begin
      low_cnt_q <= 0;
    end
  end

  a_r3_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (low_cnt_q == PULSE_CYC));

  a_r8_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n);

  a_r8_we_fall_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!cs_n));

  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r2_valid_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ack);

  a_r5_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cs_n);

  a_r6_driven_when_reading: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n) |-> out_driven);

  a_r6_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !out_driven);

  a_r9_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(addr) && $stable(din)));

  a_r10_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cs_n       (mem_cs_n),
  .we_n       (mem_we_n),
  .ready      (req_ready),
  .ack        (ack),
  .rd_valid   (rd_valid),
  .out_driven (mem_out_driven),
  .addr       (mem_addr),
  .din        (mem_din),
  .rd_data    (rd_data)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;

  localparam int AW = 8;
  localparam int DW = 4;
  localparam int ACC = 3;
  localparam int SU  = 2;
  localparam int PW  = 3;
  localparam int HD  = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          echo_mode;
  logic          req_ready;
  logic          ack;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_din;
  logic          mem_cs_n;
  logic          mem_we_n;
  logic [DW-1:0] mem_dout;
  logic          mem_out_driven;

  int checks;
  int fails;
  int model_errs;

  logic [DW-1:0] model_mem [DEPTH];
  logic [DW-1:0] exp_mem   [DEPTH];
  int            acc_cnt;
  int            wlow_cnt;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;
  logic          prev_we_n;
  logic [AW-1:0] prev_addr;

  sram_ctl #(
    .ADDR_W    (AW),
    .DATA_W    (DW),
    .ACC_CYC   (ACC),
    .SETUP_CYC (SU),
    .PULSE_CYC (PW),
    .HOLD_CYC  (HD)
  ) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .echo_mode      (echo_mode),
    .req_ready      (req_ready),
    .ack            (ack),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .mem_addr       (mem_addr),
    .mem_din        (mem_din),
    .mem_cs_n       (mem_cs_n),
    .mem_we_n       (mem_we_n),
    .mem_dout       (mem_dout),
    .mem_out_driven (mem_out_driven)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural memory: data valid only after a full access window.
  always_comb begin
    if (!mem_cs_n && mem_we_n && acc_cnt >= ACC) mem_dout = model_mem[mem_addr];
    else if (!mem_cs_n && !mem_we_n)              mem_dout = mem_din;
    else                                          mem_dout = ~model_mem[mem_addr];
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      acc_cnt   <= 0;
      wlow_cnt  <= 0;
      prev_we_n <= 1'b1;
      prev_addr <= '0;
    end else begin
      if (mem_cs_n || !mem_we_n) acc_cnt <= 0;
      else                       acc_cnt <= acc_cnt + 1;
      if (!mem_we_n && mem_cs_n) model_errs <= model_errs + 1;
      if (!mem_we_n && !prev_we_n && mem_addr != prev_addr) model_errs <= model_errs + 1;
      if (!mem_cs_n && !mem_we_n) begin
        wlow_cnt <= wlow_cnt + 1;
        w_addr   <= mem_addr;
        w_data   <= mem_din;
      end else if (wlow_cnt > 0) begin
        model_mem[w_addr] <= w_data;
        if (wlow_cnt != PW) model_errs <= model_errs + 1;
        wlow_cnt <= 0;
      end
      prev_we_n <= mem_we_n;
      prev_addr <= mem_addr;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic xact(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit mode, input bit poke);
    int len;
    bit exp_we;
    bit exp_drv;
    len = wr ? (SU + PW + HD) : ACC;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    echo_mode = mode;
    @(posedge clk);
    for (int i = 1; i <= len + 1; i++) begin
      @(negedge clk);
      if (poke && i < len) begin
        req_valid = 1'b1;
        req_write = ~wr;
        req_addr  = a ^ 8'h5A;
        req_wdata = ~d;
        echo_mode = ~mode;
      end else begin
        req_valid = 1'b0;
      end
      exp_we  = !(wr && i > SU && i <= SU + PW);
      exp_drv = (i <= len) && (exp_we || mode);
      if (i <= len) begin
        chk(wr ? "R3 cs low during write" : "R2 cs low during read", mem_cs_n, 0);
        chk(wr ? "R3 write strobe phase" : "R2 strobe high on read", mem_we_n, exp_we);
        chk("R9 address held", mem_addr, a);
        if (wr) chk("R9 data held", mem_din, d);
        chk("R5 not ready while busy", req_ready, 0);
        chk("R4 no early ack", ack, 0);
      end else begin
        chk("R2 cs released", mem_cs_n, 1);
        chk("R4 ack pulse", ack, 1);
        chk("R2 rd_valid pulse", rd_valid, !wr);
        if (!wr) chk("R2 read data", rd_data, exp_mem[a]);
        chk("R5 ready again", req_ready, 1);
      end
      chk(poke ? "R7 mode held despite input change" : "R6 output drive state",
          mem_out_driven, exp_drv);
    end
    if (wr) exp_mem[a] = d;
    @(negedge clk);
    chk("R4 ack one cycle", ack, 0);
    chk("R10 rd_valid one cycle", rd_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 0);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    checks = 0;
    fails = 0;
    model_errs = 0;
    for (int k = 0; k < DEPTH; k++) begin
      model_mem[k] = '0;
      exp_mem[k]   = '0;
    end
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    echo_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cs idle in reset", mem_cs_n, 1);
    chk("R1 we idle in reset", mem_we_n, 1);
    chk("R1 ready in reset", req_ready, 1);
    chk("R1 ack low in reset", ack, 0);
    chk("R1 rd_valid low in reset", rd_valid, 0);
    chk("R1 outputs floating in reset", mem_out_driven, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cs idle after reset", mem_cs_n, 1);
    chk("R1 ready after reset", req_ready, 1);

    // Directed corner cases
    xact(1'b1, 8'h00, 4'hA, 1'b0, 1'b0);
    xact(1'b1, 8'hFF, 4'h5, 1'b1, 1'b0);
    xact(1'b0, 8'h00, 4'h0, 1'b0, 1'b0);
    xact(1'b0, 8'hFF, 4'h0, 1'b1, 1'b0);
    held = rd_data;
    repeat (5) @(negedge clk);
    chk("R10 rd_data held while idle", rd_data, held);

    // Busy-time requests with flipped mode must be ignored (R5, R7)
    xact(1'b1, 8'h21, 4'h3, 1'b0, 1'b1);
    xact(1'b1, 8'h42, 4'hC, 1'b1, 1'b1);
    xact(1'b0, 8'h21 ^ 8'h5A, 4'h0, 1'b0, 1'b0);
    xact(1'b0, 8'h21, 4'h0, 1'b1, 1'b1);
    xact(1'b0, 8'h42, 4'h0, 1'b0, 1'b0);

    // Random write / read-back in both output modes
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 60; n++) begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        a = AW'($urandom_range(0, DEPTH - 1));
        d = DW'($urandom_range(0, 15));
        xact(1'b1, a, d, m[0], 1'b0);
      end
      for (int n = 0; n < 60; n++) begin
        logic [AW-1:0] a;
        a = AW'($urandom_range(0, DEPTH - 1));
        xact(1'b0, a, '0, m[0], 1'b0);
      end
    end

    repeat (3) @(negedge clk);
    chk("R3 memory model protocol errors", model_errs, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule